// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM with 16-bit words and 19 address lines. The host hands over one request at a time through a valid/ready handshake. A request carries an address, a write flag, a write word and two lane enables. The controller turns each request into pin activity that meets the memory's timing. The memory pins are two chip selects of opposite polarity, a write strobe, an output strobe, a select per byte lane, the address, and the data path. The data path is split into an outbound word, its drive enable and an inbound word.

Every phase length is a whole number of clock cycles. The count for a phase is the nanosecond figure for the chosen speed grade divided by the clock period, rounded up, and never less than one. When no request is in progress, the memory is deselected so that it rests in standby. After a read, the controller keeps the memory deselected and its own drivers off long enough for the memory's outputs to float, so the two sides never drive the data pins together. Read data is captured at the end of the access window. It is returned with a single-cycle valid strobe, and lanes that were not requested return zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high only while no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for RD_CYC+FLT_CYC cycles for a read and for WR_CYC+2 cycles for a write.
- R2: While idle, the memory is deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, and `mem_dq_oe`=0. This is also the state right after reset.
- R3: A read holds the chip selected, `mem_we_n` high and `mem_oe_n` low for exactly RD_CYC cycles, with `mem_addr` equal to the request address. RD_CYC is max(1, ceil(tACC/CLK_NS)), where tACC is 70 ns for the fast grade (SLOW_GRADE=0) and 100 ns for the slow grade.
- R4: Read data is captured from `mem_dq_in` at the edge that ends the last cycle of `mem_oe_n` low. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, RD_CYC edges after acceptance.
- R5: A write gives one setup cycle, then `mem_we_n` low for exactly WR_CYC = RD_CYC cycles, then one hold cycle. The chip is selected and `mem_dq_oe` is high in all three parts, and `mem_oe_n` stays high throughout.
- R6: `mem_addr`, `mem_dq_out`, `mem_lb_n` and `mem_ub_n` do not change while `mem_we_n` is low.
- R7: `mem_lb_n` is low only when `req_be[0]` was set, and it gates data bits 7:0. `mem_ub_n` is low only when `req_be[1]` was set, and it gates bits 15:8. On a read, a lane whose enable was clear returns 0x00.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, the memory stays deselected for FLT_CYC = max(1, ceil(tFLT/CLK_NS)) cycles before the next access begins. tFLT is the larger of the output-enable and chip-select float times: 35 ns fast, 40 ns slow.
- R9: A write with one lane enable clear leaves that byte of the addressed word unchanged in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| req_be | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DW | Read word, disabled lanes zero |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_lb_n | output | 1 | Active-low low-byte select |
| mem_ub_n | output | 1 | Active-low high-byte select |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
The bench samples all outputs on the falling clock edge and counts the falling edges after the accepting rising edge. With the defaults (4 ns clock, fast grade), a read keeps `req_ready` low on 18+9 sampled edges, shows `mem_oe_n` low on the first 18 of them, and shows `rsp_valid` on exactly the 19th. A write keeps `req_ready` low on 20 sampled edges and shows `mem_we_n` low on 18 of them. The bench's memory model returns garbage until `mem_oe_n` has been low for 17 rising edges, so data captured one edge early is caught. Running monitors count how many edges have passed since `mem_oe_n` was last low whenever the bus is driven, and they flag any idle edge that is not in standby.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int CLK_NS     = 4,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int AW         = 19,
  parameter int DW         = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int LW      = DW / 2;
  localparam int T_ACC   = SLOW_GRADE ? 100 : 70;
  localparam int T_OHZ   = SLOW_GRADE ? 35 : 30;
  localparam int T_CHZ   = SLOW_GRADE ? 40 : 35;
  localparam int T_FLT   = (T_OHZ > T_CHZ) ? T_OHZ : T_CHZ;

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC  = ns2cyc(T_ACC);
  localparam int WR_CYC  = RD_CYC;
  localparam int FLT_CYC = ns2cyc(T_FLT);
  localparam int CW      = $clog2(RD_CYC + FLT_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RFLT, S_WSET, S_WPUL, S_WHLD
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [1:0]    be_q;
  logic          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdat_q    <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          wdat_q <= req_wdata;
          be_q   <= req_be;
          if (req_write) st <= S_WSET;
          else begin
            st  <= S_RD;
            cnt <= CW'(RD_CYC - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_rdata <= {be_q[1] ? mem_dq_in[DW-1:LW] : LW'(0),
                        be_q[0] ? mem_dq_in[LW-1:0]  : LW'(0)};
          rsp_valid <= 1'b1;
          st        <= S_RFLT;
          cnt       <= CW'(FLT_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_RFLT: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_WSET: begin
          st  <= S_WPUL;
          cnt <= CW'(WR_CYC - 1);
        end
        S_WPUL: if (cnt == '0) st <= S_WHLD;
                else cnt <= cnt - 1'b1;
        S_WHLD: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel        = (st == S_RD) || (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);
  assign req_ready  = (st == S_IDLE);
  assign mem_ce1_n  = ~sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = (st != S_WPUL);
  assign mem_oe_n   = (st != S_RD);
  assign mem_lb_n   = ~(sel & be_q[0]);
  assign mem_ub_n   = ~(sel & be_q[1]);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdat_q;
  assign mem_dq_oe  = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r6_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lb_n) && $stable(mem_ub_n)));

  a_r2_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce1_n && mem_ce2));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
  localparam int CLK = 4;
  localparam int RD  = (70 + CLK - 1) / CLK;
  localparam int WR  = RD;
  localparam int FLT = (35 + CLK - 1) / CLK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [15:0] ram [64];
  logic [15:0] expw [64];
  int          age = 0;
  logic        csel, rd_act;

  assign csel   = !mem_ce1_n && mem_ce2;
  assign rd_act = csel && mem_we_n && !mem_oe_n;

  always @(posedge clk) begin
    age <= rd_act ? age + 1 : 0;
    if (csel && !mem_we_n) begin
      if (!mem_lb_n) ram[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) ram[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always_comb begin
    if (rd_act && age >= RD - 1)
      mem_dq_in = {mem_ub_n ? 8'hC3 : ram[mem_addr[5:0]][15:8],
                   mem_lb_n ? 8'h3C : ram[mem_addr[5:0]][7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  int total = 0, fails = 0;
  int sb_bad = 0, turn_bad = 0, st_bad = 0, addr_bad = 0;
  int since_oe = 1000;
  logic        pwe = 1'b0;
  logic [18:0] paddr;
  logic [15:0] pdat;
  logic        plb, pub;
  logic [18:0] cur_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if (req_ready && (!mem_ce1_n || mem_ce2 || !mem_we_n || !mem_oe_n || mem_dq_oe)) sb_bad++;
    if (mem_dq_oe && (!mem_oe_n || since_oe <= FLT)) turn_bad++;
    if (csel && mem_addr != cur_addr) addr_bad++;
    if (!mem_we_n && pwe && (mem_addr != paddr || mem_dq_out != pdat ||
                             mem_lb_n != plb || mem_ub_n != pub)) st_bad++;
    pwe <= !mem_we_n; paddr <= mem_addr; pdat <= mem_dq_out; plb <= mem_lb_n; pub <= mem_ub_n;
    if (!mem_oe_n) since_oe <= 0;
    else if (since_oe < 1000) since_oe <= since_oe + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input [18:0] a, input [15:0] d, input [1:0] be,
                        output logic [15:0] rd);
    int busy = 0, oel = 0, wel = 0, rv = 0, rvpos = 0;
    rd = '0;
    cur_addr = a;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 1000) begin
      busy++;
      if (!mem_oe_n) oel++;
      if (!mem_we_n) wel++;
      if (rsp_valid) begin rv++; rvpos = busy; rd = rsp_rdata; end
      @(negedge clk);
    end
    if (wr) begin
      chk(busy == WR + 2, "R1 write busy", busy, WR + 2);
      chk(wel == WR && oel == 0, "R5 strobe length", wel, WR);
    end else begin
      chk(busy == RD + FLT, "R1/R8 read busy", busy, RD + FLT);
      chk(oel == RD && wel == 0, "R3 output strobe length", oel, RD);
      chk(rv == 1 && rvpos == RD + 1, "R4 valid pulse position", rvpos, RD + 1);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 1021 + 16'h1357);
  endfunction

  logic [15:0] got;

  initial begin
    #(CLK * 150000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R2 reset state", {mem_ce1_n, mem_ce2, mem_dq_oe}, 3'b100);

    for (int a = 0; a < 64; a++) begin
      access(1'b1, {13'(a * 97), 6'(a)}, pat(a), 2'b11, got);
      expw[a] = pat(a);
    end
    for (int a = 0; a < 64; a++) begin
      access(1'b0, {13'(a * 97), 6'(a)}, 16'h0, 2'b11, got);
      chk(got == expw[a], "R4 full word read", got, expw[a]);
    end

    for (int a = 0; a < 64; a++) begin
      logic [1:0] be = a[0] ? 2'b01 : 2'b10;
      logic [15:0] d = ~pat(a + 7);
      access(1'b1, {13'(a * 31), 6'(a)}, d, be, got);
      if (be[0]) expw[a][7:0] = d[7:0];
      else       expw[a][15:8] = d[15:8];
    end
    for (int a = 0; a < 64; a++) begin
      access(1'b0, {13'(a), 6'(a)}, 16'h0, 2'b11, got);
      chk(got == expw[a], "R9 lane-masked write readback", got, expw[a]);
    end

    for (int a = 0; a < 16; a++) begin
      access(1'b0, {13'd5, 6'(a)}, 16'h0, 2'b01, got);
      chk(got == {8'h00, expw[a][7:0]}, "R7 low lane read", got, {8'h00, expw[a][7:0]});
      access(1'b0, {13'd6, 6'(a)}, 16'h0, 2'b10, got);
      chk(got == {expw[a][15:8], 8'h00}, "R7 high lane read", got, {expw[a][15:8], 8'h00});
      access(1'b0, {13'd7, 6'(a)}, 16'h0, 2'b00, got);
      chk(got == 16'h0000, "R7 no lane read", got, 0);
    end

    for (int a = 0; a < 8; a++) begin
      access(1'b0, 19'(a), 16'h0, 2'b11, got);
      access(1'b1, 19'(a), 16'hA500 + 16'(a), 2'b11, got);
      expw[a] = 16'hA500 + 16'(a);
      access(1'b0, 19'(a), 16'h0, 2'b11, got);
      chk(got == expw[a], "R8 read-write-read turnaround", got, expw[a]);
    end

    chk(sb_bad == 0, "R2 idle standby", sb_bad, 0);
    chk(turn_bad == 0, "R8 float gap before drive", turn_bad, 0);
    chk(st_bad == 0, "R6 stable while strobe low", st_bad, 0);
    chk(addr_bad == 0, "R3 address presented", addr_bad, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule